// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block sits on the host side of a PCI hierarchy and converts processor register accesses into configuration transactions. The processor first writes a configuration-address word into the lower part of the bridge's register region, then reads or writes the upper part (the data window). The stored word carries an enable flag and the bus, device, function and register offset of the target, packed in a byte-swapped arrangement.

Each data-window access is steered to one of four destinations. The bridge's own small configuration header answers device 0, function 0 on bus 0. A few slot devices answer fixed device numbers on bus 0 (type 0). Any access with a nonzero bus becomes a downstream (type 1) request. Every other access finds no device. Slot and downstream accesses use a plain request/acknowledge interface. Sub-word writes to those targets are done as read-merge-write. The processor side sees one `reg_ack` pulse when each access completes.

The control state machine has four states. `S_IDLE` accepts an access. It goes to `S_FETCH` for a device read or a sub-word device write, to `S_STORE` for a full-word device write, and to `S_DONE` for everything it completes by itself. `S_FETCH` waits for `dev_ack`, then goes to `S_STORE` for a write or to `S_DONE` for a read. `S_STORE` waits for `dev_ack`, then goes to `S_DONE`. `S_DONE` raises `reg_ack` for one cycle and returns to `S_IDLE`.

Top module: `pci_cfg_bridge`

## Requirements
- R1: After reset, `reg_ack` and `dev_req` are low and the stored configuration address is zero, so the data window starts out disabled.
- R2: A write with `reg_addr` below 0x200000 stores the whole `reg_wdata` as the configuration address and raises no device request. A read there returns 0.
- R3: When bit 7 of the stored address (the enable flag) is 0, a data-window access (`reg_addr` at or above 0x200000) has no effect. No device request is made, the own header is unchanged, and a read returns 0.
- R4: The stored address is decoded as follows: register offset from bits 31:24 with bits 1:0 forced to 0, device from bits 23:19, function from bits 18:16, bus from bits 15:8. A nonzero bus gives a type 1 request (`dev_type1`=1, `dev_slot`=0) that carries these fields.
- R5: Bus 0, device 0, function 0 selects the own header. Word 0x00 reads 0x00021057, word 0x08 reads 0x06000040, word 0x04 reads status 0x0080 above the command word (reset 0x0006), and word 0x0C reads the line size in byte 0 (reset 0x08). Other words read 0.
- R6: On bus 0, device numbers 13, 14 and 15 (any function) select slots 0, 1 and 2 when the matching `slot_fitted` bit is set. The request is type 0, with `dev_slot` one-hot.
- R7: A read that selects no device returns all ones, lane-extracted per R9. A write to a missing device raises no device request.
- R8: A device write with `reg_size`=4 is sent as one write with no read. A narrower write first reads the word, then writes it back with the new bytes merged at lane `reg_addr[1:0]`.
- R9: `reg_size` gives the access width (1, 2 or 4 bytes) and `reg_addr[1:0]` the starting byte lane. Read data is shifted down from that lane and zero-extended.
- R10: In the own header, only the command word and the line-size byte are writable (sub-word writes merge). The IDs, class/revision and status ignore writes.
- R11: `dev_req` stays high with stable fields until `dev_ack`. Each access produces exactly one single-cycle `reg_ack`, and `reg_rdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 22 | Offset within the bridge register region |
| reg_wdata | input | 32 | Write data, right-aligned for sub-word sizes |
| reg_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rdata | output | 32 | Read data, valid with reg_ack |
| reg_ack | output | 1 | Access complete pulse |
| slot_fitted | input | 3 | Slot presence mask |
| dev_req | output | 1 | Device request, held until dev_ack |
| dev_we | output | 1 | Device request is a write |
| dev_type1 | output | 1 | Request goes downstream (nonzero bus) |
| dev_slot | output | 3 | One-hot slot select for type 0 requests |
| dev_bus | output | 8 | Bus number |
| dev_dev | output | 5 | Device number |
| dev_fn | output | 3 | Function number |
| dev_reg | output | 8 | Dword-aligned register offset |
| dev_wdata | output | 32 | Full-word write data |
| dev_rdata | input | 32 | Device read data, valid with dev_ack |
| dev_ack | input | 1 | Device completion |

## Verification
The assertions assume the host issues at most one strobe at a time and only while no access is in flight. They also assume the host leaves the address register alone until `reg_ack`, and that `dev_ack` only arrives while `dev_req` is high. The bench waits for each `reg_ack` before it issues the next strobe. Its device model acknowledges only a pending request, after a random delay of zero to two cycles, and drops the acknowledge on the following cycle. Random addresses mix bus zero and nonzero buses, the own device, fitted and unfitted slots and empty device numbers. Lanes are always aligned to the access size.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_STORE, S_DONE} brg_state_e;
    typedef enum logic [1:0] {T_OWN, T_SLOT, T_DOWN, T_NONE} tgt_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [7:0] off;
    } cfg_fields_t;

    function automatic logic [31:0] size_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] lane_extract(input logic [31:0] word,
                                                 input logic [1:0] lane,
                                                 input logic [2:0] sz);
        return (word >> {lane, 3'b000}) & size_mask(sz);
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                               input logic [31:0] nw,
                                               input logic [1:0] lane,
                                               input logic [2:0] sz);
        logic [31:0] m;
        m = size_mask(sz) << {lane, 3'b000};
        return (old & ~m) | ((nw << {lane, 3'b000}) & m);
    endfunction
endpackage

// File: rtl/pcicfg_decode.sv
module pcicfg_decode
    import pcicfg_pkg::*;
#(
    parameter int NSLOT     = 3,
    parameter int SLOT_BASE = 13
) (
    input  logic [31:0]      cfg_addr,
    input  logic [NSLOT-1:0] slot_fitted,
    output cfg_fields_t      fld,
    output tgt_e             tgt,
    output logic [NSLOT-1:0] slot_oh
);
    always_comb begin
        fld.en  = cfg_addr[7];
        fld.bus = cfg_addr[15:8];
        fld.fn  = cfg_addr[18:16];
        fld.dev = cfg_addr[23:19];
        fld.off = {cfg_addr[31:26], 2'b00};
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign slot_oh[i] = slot_fitted[i] && (fld.bus == 8'd0) &&
                            (fld.dev == 5'(SLOT_BASE + i));
    end

    always_comb begin
        if (fld.bus != 8'd0)
            tgt = T_DOWN;
        else if (fld.dev == 5'd0 && fld.fn == 3'd0)
            tgt = T_OWN;
        else if (|slot_oh)
            tgt = T_SLOT;
        else
            tgt = T_NONE;
    end
endmodule

// File: rtl/pcicfg_own_hdr.sv
module pcicfg_own_hdr #(
    parameter logic [15:0] VENDOR    = 16'h1057,
    parameter logic [15:0] DEVICE    = 16'h0002,
    parameter logic [31:0] CLASS_REV = 32'h0600_0040,
    parameter logic [15:0] CMD_RST   = 16'h0006,
    parameter logic [15:0] STATUS    = 16'h0080,
    parameter logic [7:0]  CLS_RST   = 8'h08
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  off,
    input  logic        wr_en,
    input  logic [31:0] wr_word,
    output logic [31:0] rd_word
);
    localparam logic [7:0] OFF_ID    = 8'h00;
    localparam logic [7:0] OFF_CMD   = 8'h04;
    localparam logic [7:0] OFF_CLASS = 8'h08;
    localparam logic [7:0] OFF_LINE  = 8'h0C;

    logic [15:0] cmd_q;
    logic [7:0]  line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_RST;
            line_q <= CLS_RST;
        end else if (wr_en) begin
            if (off == OFF_CMD)  cmd_q  <= wr_word[15:0];
            if (off == OFF_LINE) line_q <= wr_word[7:0];
        end
    end

    always_comb begin
        unique case (off)
            OFF_ID:    rd_word = {DEVICE, VENDOR};
            OFF_CMD:   rd_word = {STATUS, cmd_q};
            OFF_CLASS: rd_word = CLASS_REV;
            OFF_LINE:  rd_word = {24'h0, line_q};
            default:   rd_word = 32'h0;
        endcase
    end
endmodule

// File: rtl/pci_cfg_bridge.sv
module pci_cfg_bridge
    import pcicfg_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_BASE = 32'h0020_0000,
    parameter int NSLOT     = 3,
    parameter int SLOT_BASE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_size,
    input  logic              reg_rd,
    input  logic              reg_wr,
    output logic [31:0]       reg_rdata,
    output logic              reg_ack,
    input  logic [NSLOT-1:0]  slot_fitted,
    output logic              dev_req,
    output logic              dev_we,
    output logic              dev_type1,
    output logic [NSLOT-1:0]  dev_slot,
    output logic [7:0]        dev_bus,
    output logic [4:0]        dev_dev,
    output logic [2:0]        dev_fn,
    output logic [7:0]        dev_reg,
    output logic [31:0]       dev_wdata,
    input  logic [31:0]       dev_rdata,
    input  logic              dev_ack
);
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(DATA_BASE);

    brg_state_e  state_q, state_d;
    logic [31:0] cfg_q, rdata_q, wbuf_q, own_rd, own_wr_word;
    logic [1:0]  lane_q;
    logic [2:0]  sz_q;
    logic        wr_q;
    cfg_fields_t fld;
    tgt_e        tgt;
    logic [NSLOT-1:0] slot_oh;

    logic access, is_data, live, to_dev, own_wr_en;

    pcicfg_decode #(.NSLOT(NSLOT), .SLOT_BASE(SLOT_BASE)) u_dec (
        .cfg_addr(cfg_q), .slot_fitted(slot_fitted),
        .fld(fld), .tgt(tgt), .slot_oh(slot_oh)
    );

    pcicfg_own_hdr u_hdr (
        .clk(clk), .rst_n(rst_n), .off(fld.off),
        .wr_en(own_wr_en), .wr_word(own_wr_word), .rd_word(own_rd)
    );

    assign access      = reg_rd | reg_wr;
    assign is_data     = reg_addr >= WIN_BASE;
    assign live        = access && is_data && fld.en;
    assign to_dev      = (tgt == T_SLOT) || (tgt == T_DOWN);
    assign own_wr_en   = (state_q == S_IDLE) && reg_wr && live && (tgt == T_OWN);
    assign own_wr_word = lane_merge(own_rd, reg_wdata, reg_addr[1:0], reg_size);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (access) begin
                if (live && to_dev)
                    state_d = (reg_wr && reg_size == 3'd4) ? S_STORE : S_FETCH;
                else
                    state_d = S_DONE;
            end
            S_FETCH: if (dev_ack) state_d = wr_q ? S_STORE : S_DONE;
            S_STORE: if (dev_ack) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dev_req   = (state_q == S_FETCH) || (state_q == S_STORE);
        dev_we    = (state_q == S_STORE);
        reg_ack   = (state_q == S_DONE);
        dev_type1 = (tgt == T_DOWN);
        dev_slot  = (tgt == T_SLOT) ? slot_oh : '0;
        dev_bus   = fld.bus;
        dev_dev   = fld.dev;
        dev_fn    = fld.fn;
        dev_reg   = fld.off;
        dev_wdata = wbuf_q;
        reg_rdata = rdata_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            rdata_q <= '0;
            wbuf_q  <= '0;
            lane_q  <= '0;
            sz_q    <= 3'd4;
            wr_q    <= 1'b0;
        end else begin
            if (state_q == S_IDLE && access) begin
                lane_q <= reg_addr[1:0];
                sz_q   <= reg_size;
                wr_q   <= reg_wr;
                wbuf_q <= reg_wdata;
                if (reg_wr && !is_data) cfg_q <= reg_wdata;
                if (reg_wr || !live)
                    rdata_q <= '0;
                else if (tgt == T_OWN)
                    rdata_q <= lane_extract(own_rd, reg_addr[1:0], reg_size);
                else if (tgt == T_NONE)
                    rdata_q <= lane_extract(32'hFFFF_FFFF, reg_addr[1:0], reg_size);
                else
                    rdata_q <= '0;
            end
            if (state_q == S_FETCH && dev_ack) begin
                if (wr_q) wbuf_q  <= lane_merge(dev_rdata, wbuf_q, lane_q, sz_q);
                else      rdata_q <= lane_extract(dev_rdata, lane_q, sz_q);
            end
        end
    end

    // R3: a disabled data access never reaches a device
    a_r3_disabled_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && access && is_data && !cfg_q[7]) |=> !dev_req);

    // R11: request held stable until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> (dev_req && $stable(dev_we) && $stable(dev_reg)
                                   && $stable(dev_wdata)));

    // R11: completion is a single-cycle pulse
    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |=> !reg_ack);

    // R8: a write that starts without a fetch is a full-word write
    a_r8_full_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dev_req) && dev_we) |-> (sz_q == 3'd4));

    // R4: type follows the bus number
    a_r4_type_by_bus: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req |-> (dev_type1 == (dev_bus != 8'd0)));

    // R6: type 0 requests select exactly one slot
    a_r6_slot_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_type1) |-> ($countones(dev_slot) == 1));
endmodule

// File: tb/pci_cfg_bridge_tb.sv
module pci_cfg_bridge_tb;
    import pcicfg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_size = 3'd4;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic        reg_ack;
    logic [2:0]  fitted = 3'b011;
    logic        dev_req, dev_we, dev_type1;
    logic [2:0]  dev_slot;
    logic [7:0]  dev_bus, dev_reg;
    logic [4:0]  dev_dev;
    logic [2:0]  dev_fn;
    logic [31:0] dev_wdata;
    logic [31:0] dev_rdata = '0;
    logic        dev_ack = 1'b0;

    int n_chk = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, wait_cnt = 0;
    logic        cap_t1;
    logic [2:0]  cap_slot;
    logic [23:0] cap_fld;
    logic [31:0] cap_wdata;
    logic [31:0] cur_cfg = '0;
    logic [15:0] m_cmd = 16'h0006;
    logic [7:0]  m_line = 8'h08;

    always #5 clk = ~clk;

    pci_cfg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_size(reg_size), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .reg_ack(reg_ack), .slot_fitted(fitted),
        .dev_req(dev_req), .dev_we(dev_we), .dev_type1(dev_type1),
        .dev_slot(dev_slot), .dev_bus(dev_bus), .dev_dev(dev_dev),
        .dev_fn(dev_fn), .dev_reg(dev_reg), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_ack(dev_ack)
    );

    function automatic logic [31:0] dev_word(logic [7:0] bus, logic [4:0] dv,
                                             logic [2:0] fn, logic [7:0] off);
        return {off ^ 8'hC3, bus, 3'b101, dv, fn, 5'h0A};
    endfunction

    function automatic logic [31:0] own_word(logic [7:0] off);
        case (off)
            8'h00:   return 32'h0002_1057;
            8'h04:   return {16'h0080, m_cmd};
            8'h08:   return 32'h0600_0040;
            8'h0C:   return {24'h0, m_line};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] mk_cfg(logic en, logic [7:0] bus, logic [4:0] dv,
                                           logic [2:0] fn, logic [7:0] off);
        return {off, dv, fn, bus, en, 7'h0};
    endfunction

    // device model
    always @(negedge clk) begin
        if (dev_ack) dev_ack <= 1'b0;
        else if (dev_req) begin
            if (wait_cnt == 0) begin
                dev_ack  <= 1'b1;
                cap_t1   = dev_type1;
                cap_slot = dev_slot;
                cap_fld  = {dev_bus, dev_dev, dev_fn, dev_reg};
                if (dev_we) begin n_wr++; cap_wdata = dev_wdata; end
                else begin n_rd++; dev_rdata <= dev_word(dev_bus, dev_dev, dev_fn, dev_reg); end
                wait_cnt = $urandom % 3;
            end else wait_cnt--;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [21:0] a, input logic [31:0] wd,
                       input logic [2:0] sz, output logic [31:0] rd);
        int t;
        @(negedge clk);
        n_rd = 0; n_wr = 0;
        reg_addr = a; reg_wdata = wd; reg_size = sz; reg_rd = !wr; reg_wr = wr;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        t = 0;
        while (!reg_ack && t < 60) begin @(negedge clk); t++; end
        if (!reg_ack) chk("R11 ack timeout", 32'd0, 32'd1);
        rd = reg_rdata;
    endtask

    task automatic set_cfg(input logic [31:0] w);
        logic [31:0] rd;
        acc(1'b1, 22'(($urandom % 32'h1F_FFFF) & 32'h1F_FFFC), w, 3'd4, rd);
        cur_cfg = w;
        chk("R2 no device traffic on addr write", n_rd + n_wr, 0);
    endtask

    task automatic data_op(input logic wr, input logic [1:0] lane, input logic [2:0] sz,
                           input logic [31:0] wd, input string tag);
        logic [31:0] rd, ow;
        logic [7:0] bus, off;
        logic [4:0] dv;
        logic [2:0] fn;
        logic en;
        int s;
        en = cur_cfg[7]; bus = cur_cfg[15:8]; fn = cur_cfg[18:16];
        dv = cur_cfg[23:19]; off = {cur_cfg[31:26], 2'b00};
        acc(wr, 22'h20_0000 | 22'(lane) | 22'(($urandom % 16) << 4), wd, sz, rd);
        s = int'(dv) - 13;
        if (!en) begin
            chk({tag, " R3 disabled no traffic"}, n_rd + n_wr, 0);
            if (!wr) chk({tag, " R3 disabled reads 0"}, rd, 0);
        end else if (bus != 0 || (dv >= 13 && dv <= 15 && fitted[s % 3])) begin
            chk({tag, " R4/R6 fields"}, {8'h0, cap_fld}, {8'h0, bus, dv, fn, off});
            chk({tag, " R4/R6 type/slot"}, {cap_t1, cap_slot},
                (bus != 0) ? 4'b1000 : {1'b0, 3'(1 << s)});
            if (!wr) begin
                chk({tag, " R9 device read lane"}, rd, lane_extract(dev_word(bus, dv, fn, off), lane, sz));
                chk({tag, " R11 one read"}, n_rd * 16 + n_wr, 16);
            end else if (sz == 3'd4) begin
                chk({tag, " R8 full write no fetch"}, n_rd * 16 + n_wr, 1);
                chk({tag, " R8 full data"}, cap_wdata, wd);
            end else begin
                chk({tag, " R8 rmw count"}, n_rd * 16 + n_wr, 17);
                chk({tag, " R8 merged data"}, cap_wdata,
                    lane_merge(dev_word(bus, dv, fn, off), wd, lane, sz));
            end
        end else if (dv == 0 && fn == 0) begin
            chk({tag, " R5 own no traffic"}, n_rd + n_wr, 0);
            ow = own_word(off);
            if (!wr) chk({tag, " R5/R9 own read"}, rd, lane_extract(ow, lane, sz));
            else begin
                ow = lane_merge(ow, wd, lane, sz);
                if (off == 8'h04) m_cmd = ow[15:0];
                if (off == 8'h0C) m_line = ow[7:0];
            end
        end else begin
            chk({tag, " R7 missing no traffic"}, n_rd + n_wr, 0);
            if (!wr) chk({tag, " R7 missing reads ones"}, rd, lane_extract(32'hFFFF_FFFF, lane, sz));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("R11 watchdog expired", 32'd0, 32'd1);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [2:0] sz;
        logic [1:0] ln;
        logic [4:0] dv;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset ack", reg_ack, 0);
        chk("R1 reset req", dev_req, 0);
        rst_n = 1'b1;
        data_op(1'b0, 2'd0, 3'd4, 0, "R1 data window disabled after reset");
        acc(1'b0, 22'h00_0000, 0, 3'd4, rd);
        chk("R2 addr read is 0", rd, 0);

        // own header (R5, R10)
        set_cfg(mk_cfg(1, 0, 0, 0, 8'h00)); data_op(0, 0, 4, 0, "R5 ids");
        data_op(0, 2, 2, 0, "R9 device id half");
        set_cfg(mk_cfg(1, 0, 0, 0, 8'h08)); data_op(0, 3, 1, 0, "R5 class byte3");
        data_op(1, 0, 4, 32'hDEAD_BEEF, "R10 class ro");
        data_op(0, 0, 4, 0, "R10 class unchanged");
        set_cfg(mk_cfg(1, 0, 0, 0, 8'h04)); data_op(0, 0, 4, 0, "R5 cmd/status");
        data_op(1, 0, 4, 32'hFFFF_FFFF, "R10 cmd write");
        data_op(0, 0, 4, 0, "R10 status ro");
        data_op(1, 1, 1, 32'h0000_0012, "R10 cmd byte merge");
        data_op(0, 0, 4, 0, "R10 cmd merged");
        set_cfg(mk_cfg(1, 0, 0, 0, 8'h0C)); data_op(0, 0, 4, 0, "R5 line size");
        data_op(1, 0, 1, 32'h0000_0020, "R10 line write");
        data_op(0, 0, 1, 0, "R10 line read");
        // R3: enable clear, own header untouched
        set_cfg(mk_cfg(0, 0, 0, 0, 8'h0C)); data_op(1, 0, 1, 32'h55, "R3 ignored write");
        set_cfg(mk_cfg(1, 0, 0, 0, 8'h0C)); data_op(0, 0, 4, 0, "R3 line unchanged");
        // R4: type 1, offset low bits forced
        set_cfg({8'h47, 5'd3, 3'd5, 8'h21, 1'b1, 7'h0}); data_op(0, 0, 4, 0, "R4 type1 read");
        chk("R4 offset low bits zero", {24'h0, cap_fld[7:0]}, 32'h44);
        data_op(1, 2, 2, 32'h0000_ABCD, "R8 type1 half write");
        // slots (R6, R7)
        set_cfg(mk_cfg(1, 0, 5'd13, 3'd2, 8'h10)); data_op(0, 1, 1, 0, "R6 slot0 read");
        set_cfg(mk_cfg(1, 0, 5'd14, 3'd0, 8'h3C)); data_op(1, 0, 4, 32'h1234_5678, "R8 slot1 full");
        set_cfg(mk_cfg(1, 0, 5'd15, 3'd0, 8'h00)); data_op(0, 3, 1, 0, "R7 unfitted slot2 byte");
        data_op(1, 0, 4, 32'h1, "R7 unfitted write dropped");
        fitted = 3'b111; data_op(0, 0, 2, 0, "R6 slot2 fitted"); fitted = 3'b011;
        set_cfg(mk_cfg(1, 0, 5'd0, 3'd1, 8'h00)); data_op(0, 0, 4, 0, "R7 dev0 fn1 missing");
        set_cfg(mk_cfg(1, 0, 5'd7, 3'd0, 8'h00)); data_op(0, 2, 2, 0, "R7 dev7 missing half");

        // random phase
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 5)
                0: dv = 5'd0; 1: dv = 5'd13; 2: dv = 5'd14; 3: dv = 5'd15;
                default: dv = 5'($urandom);
            endcase
            set_cfg(mk_cfg(($urandom % 8) != 0, ($urandom % 2) ? 8'($urandom) : 8'h0, dv,
                           ($urandom % 3 == 0) ? 3'($urandom) : 3'd0,
                           ($urandom % 2) ? 8'(4 * ($urandom % 4)) : 8'($urandom)));
            fitted = ($urandom % 4 == 0) ? 3'($urandom) : 3'b011;
            for (int j = 0; j < 2; j++) begin
                case ($urandom % 3) 0: sz = 3'd1; 1: sz = 3'd2; default: sz = 3'd4; endcase
                ln = (sz == 3'd4) ? 2'd0 : (sz == 3'd2) ? 2'($urandom % 2) * 2'd2 : 2'($urandom);
                data_op($urandom % 2, ln, sz, $urandom, "R9 random");
            end
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule